// File: doc/BRIEF.md
# PCI Configuration Register File

This block holds the target-side configuration header of a PCI network function, together with its capability list. A bus-side agent reaches it through a plain register port: a byte address, four byte enables, 32-bit write data, and single-cycle read and write strobes. The agent decodes PCI configuration cycles and turns them into these accesses. Reads return the aligned 32-bit word that holds the addressed byte. Writes update only the byte lanes whose enables are set, and only the bits in those lanes that are writable.

The identity fields come from an external EEPROM loader when one is present, and fall back to built-in defaults when it is not. The fast back-to-back enable in the command word is writable only while a device-side permit input is high. An address-phase parity error raises a one-cycle system-error request when the system-error enable is set. Two capabilities are chained: power management first, then vital product data. The power-state field and the command bits are driven out to the rest of the function.

Top module: `pcicfg_regfile`

## Requirements
- R1: After reset, the command outputs, the power-state output and the system-error request are 0, and the power-management control word (dword at 8'hE0) reads 0.
- R2: Dword 8'h00 reads {device ID, vendor ID}. With `rom_present` low it reads 32'h8129_10EC. With `rom_present` high it reads {`rom_device`, `rom_vendor`}.
- R3: Command bit 9 (fast back-to-back enable) reads 0 and keeps its stored value on writes while `fb2b_permit` is 0. While `fb2b_permit` is 1 it is read/write.
- R4: When command bit 8 is 1, a cycle with `addr_parity_err` high gives `serr_req` high for exactly the next cycle. When bit 8 is 0, `serr_req` stays low.
- R5: Command bits 15:10, bit 7 and bits 5:3 always read 0. Only bits 0, 1, 2, 6 and 8 (the default writable mask 16'h0147) and bit 9 (under R3) store written values.
- R6: The status half of dword 8'h04 reads 16'h0010 (capabilities-list flag at bit 4) and ignores writes. Offset 8'h34 reads 8'hDC.
- R7: Dword 8'hDC reads {PMC word 16'h0002, next 8'h60, ID 8'h01}. Dword 8'h60 reads {VPD address word, next 8'h00, ID 8'h03}, and its two low bytes ignore writes.
- R8: Byte 8'hE0 bits 1:0 are a read/write power state, driven on `pwr_state`. Bits 7:2 of that byte read 0.
- R9: Byte 8'hE1 bit 0 is a read/write PME enable. Bit 7 is PME status: `pme_event` sets it, and writing 1 to it clears it. A set in the same cycle as a clear wins.
- R10: A write changes only the bytes whose enable bit is set (bit i covers data bits 8i+7:8i). The VPD data word at 8'h64 stores all four bytes.
- R11: Offsets 8'h40–8'h5F, 8'h68–8'hDB and 8'hE4–8'hFF read 0, and writes to them have no effect.
- R12: `acc_rdata` takes the word for dword index `acc_addr[7:2]` at the clock edge where `acc_rd` is high, so it is valid one cycle after the strobe. It holds its value while `acc_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 8 | Byte address of the access |
| acc_be | input | 4 | Byte-lane enables for writes |
| acc_wdata | input | 32 | Write data |
| acc_rd | input | 1 | Read strobe |
| acc_wr | input | 1 | Write strobe |
| acc_rdata | output | 32 | Registered read data |
| rom_present | input | 1 | EEPROM identity values are valid |
| rom_vendor | input | 16 | Vendor ID from EEPROM |
| rom_device | input | 16 | Device ID from EEPROM |
| fb2b_permit | input | 1 | Allows the fast back-to-back enable to be written |
| addr_parity_err | input | 1 | Address-phase parity error pulse |
| pme_event | input | 1 | Device-side PME event, sets PME status |
| cmd_bits | output | 16 | Effective command register value |
| serr_req | output | 1 | One-cycle system-error request |
| pwr_state | output | 2 | Current power state |

## Verification
The bench builds the block with its default parameters. These are the writable command mask 16'h0147, the PMC word 16'h0002, the built-in IDs 16'h10EC/16'h8129, and the VPD capability present. With these values the full chain 8'h34 → 8'hDC → 8'h60 → end can be walked, and both the reserved gap before and the gap after the VPD registers can be read. Because the VPD data word stores all four lanes, any mix of byte enables can be checked there. The permit input is toggled around command writes, and a PME event is made to coincide with a write-one-to-clear, so that both gated-write cases and the set-versus-clear priority are observed at the ports.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

   localparam int DW_IDX_W = 6;

   localparam logic [DW_IDX_W-1:0] DW_IDENT   = 6'h00;
   localparam logic [DW_IDX_W-1:0] DW_CMDSTAT = 6'h01;
   localparam logic [DW_IDX_W-1:0] DW_CAPPTR  = 6'h0D;
   localparam logic [DW_IDX_W-1:0] DW_VPD_HDR = 6'h18;
   localparam logic [DW_IDX_W-1:0] DW_VPD_DAT = 6'h19;
   localparam logic [DW_IDX_W-1:0] DW_PM_HDR  = 6'h37;
   localparam logic [DW_IDX_W-1:0] DW_PM_CTL  = 6'h38;

   localparam logic [7:0] PM_CAP_OFS  = 8'hDC;
   localparam logic [7:0] VPD_CAP_OFS = 8'h60;
   localparam logic [7:0] PM_CAP_ID   = 8'h01;
   localparam logic [7:0] VPD_CAP_ID  = 8'h03;

   localparam logic [15:0] STATUS_RO  = 16'h0010;

   typedef struct packed {
      logic [31:0] data;
      logic [3:0]  be;
   } wbus_t;

   function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
      logic [31:0] r;
      r = old_v;
      for (int i = 0; i < 4; i++)
         if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
      return r;
   endfunction

endpackage

// File: rtl/pcicfg_cmd.sv
module pcicfg_cmd
   import pcicfg_pkg::*;
#(
   parameter logic [15:0] RW_MASK = 16'h0147
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  wbus_t       wb,
   input  logic        fb2b_permit,
   input  logic        perr,
   output logic [15:0] cmd_q,
   output logic        serr_req
);
   localparam logic [15:0] PLAIN = RW_MASK & ~16'h0200;

   logic [15:0] plain_q;
   logic        fb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         plain_q  <= '0;
         fb_q     <= 1'b0;
         serr_req <= 1'b0;
      end else begin
         if (wr_hit && wb.be[0])
            plain_q[7:0] <= wb.data[7:0] & PLAIN[7:0];
         if (wr_hit && wb.be[1]) begin
            plain_q[15:8] <= wb.data[15:8] & PLAIN[15:8];
            if (fb2b_permit)
               fb_q <= wb.data[9];
         end
         serr_req <= perr & cmd_q[8];
      end
   end

   always_comb begin
      cmd_q    = plain_q;
      cmd_q[9] = fb_q & fb2b_permit;
   end

endmodule

// File: rtl/pcicfg_pm.sv
module pcicfg_pm
   import pcicfg_pkg::*;
#(
   parameter logic [15:0] PMC_WORD = 16'h0002,
   parameter logic [7:0]  NEXT_PTR = 8'h60
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  wbus_t       wb,
   input  logic        pme_event,
   output logic [1:0]  pwr_state,
   output logic [31:0] hdr_word,
   output logic [31:0] ctl_word
);
   logic pme_en_q;
   logic pme_sts_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_state <= 2'b00;
         pme_en_q  <= 1'b0;
         pme_sts_q <= 1'b0;
      end else begin
         if (wr_hit && wb.be[0])
            pwr_state <= wb.data[1:0];
         if (wr_hit && wb.be[1])
            pme_en_q <= wb.data[8];
         if (pme_event)
            pme_sts_q <= 1'b1;
         else if (wr_hit && wb.be[1] && wb.data[15])
            pme_sts_q <= 1'b0;
      end
   end

   assign hdr_word = {PMC_WORD, NEXT_PTR, PM_CAP_ID};
   assign ctl_word = {16'h0000, pme_sts_q, 6'b0, pme_en_q, 6'b0, pwr_state};

endmodule

// File: rtl/pcicfg_vpd.sv
module pcicfg_vpd
   import pcicfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hdr_hit,
   input  logic        dat_hit,
   input  wbus_t       wb,
   output logic [31:0] hdr_word,
   output logic [31:0] dat_word
);
   logic [15:0] vaddr_q;
   logic [31:0] vdata_q;
   logic [31:0] hdr_merged;

   assign hdr_merged = lane_merge({vaddr_q, 16'h0000}, wb.data, wb.be);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vaddr_q <= '0;
         vdata_q <= '0;
      end else begin
         if (hdr_hit)
            vaddr_q <= hdr_merged[31:16];
         if (dat_hit)
            vdata_q <= lane_merge(vdata_q, wb.data, wb.be);
      end
   end

   assign hdr_word = {vaddr_q, 8'h00, VPD_CAP_ID};
   assign dat_word = vdata_q;

endmodule

// File: rtl/pcicfg_rdmux.sv
module pcicfg_rdmux
   import pcicfg_pkg::*;
(
   input  logic [DW_IDX_W-1:0] dw_idx,
   input  logic [31:0]         ident_w,
   input  logic [31:0]         cmdstat_w,
   input  logic [31:0]         vpd_hdr_w,
   input  logic [31:0]         vpd_dat_w,
   input  logic [31:0]         pm_hdr_w,
   input  logic [31:0]         pm_ctl_w,
   output logic [31:0]         rd_word
);
   always_comb begin
      unique case (dw_idx)
         DW_IDENT:   rd_word = ident_w;
         DW_CMDSTAT: rd_word = cmdstat_w;
         DW_CAPPTR:  rd_word = {24'h0, PM_CAP_OFS};
         DW_VPD_HDR: rd_word = vpd_hdr_w;
         DW_VPD_DAT: rd_word = vpd_dat_w;
         DW_PM_HDR:  rd_word = pm_hdr_w;
         DW_PM_CTL:  rd_word = pm_ctl_w;
         default:    rd_word = '0;
      endcase
   end

endmodule

// File: rtl/pcicfg_regfile.sv
module pcicfg_regfile
   import pcicfg_pkg::*;
#(
   parameter logic [15:0] DFLT_VENDOR = 16'h10EC,
   parameter logic [15:0] DFLT_DEVICE = 16'h8129,
   parameter logic [15:0] CMD_RW_MASK = 16'h0147,
   parameter logic [15:0] PMC_WORD    = 16'h0002,
   parameter bit          HAS_VPD     = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  acc_addr,
   input  logic [3:0]  acc_be,
   input  logic [31:0] acc_wdata,
   input  logic        acc_rd,
   input  logic        acc_wr,
   output logic [31:0] acc_rdata,
   input  logic        rom_present,
   input  logic [15:0] rom_vendor,
   input  logic [15:0] rom_device,
   input  logic        fb2b_permit,
   input  logic        addr_parity_err,
   input  logic        pme_event,
   output logic [15:0] cmd_bits,
   output logic        serr_req,
   output logic [1:0]  pwr_state
);
   localparam logic [15:0] CMD_FORBIDDEN = 16'hFEB8;
   localparam logic [7:0]  PM_NEXT       = HAS_VPD ? VPD_CAP_OFS : 8'h00;

   if ((CMD_RW_MASK & CMD_FORBIDDEN) != 16'h0000) begin : g_bad_mask
      $error("CMD_RW_MASK selects reserved or hardwired command bits");
   end

   logic [DW_IDX_W-1:0] dw_idx;
   wbus_t               wb;
   logic [31:0]         ident_w, cmdstat_w, vpd_hdr_w, vpd_dat_w;
   logic [31:0]         pm_hdr_w, pm_ctl_w, rd_word;

   assign dw_idx  = acc_addr[7:2];
   assign wb.data = acc_wdata;
   assign wb.be   = acc_be;

   assign ident_w   = rom_present ? {rom_device, rom_vendor}
                                  : {DFLT_DEVICE, DFLT_VENDOR};
   assign cmdstat_w = {STATUS_RO, cmd_bits};

   pcicfg_cmd #(.RW_MASK(CMD_RW_MASK)) cmd_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_hit      (acc_wr && dw_idx == DW_CMDSTAT),
      .wb          (wb),
      .fb2b_permit (fb2b_permit),
      .perr        (addr_parity_err),
      .cmd_q       (cmd_bits),
      .serr_req    (serr_req)
   );

   pcicfg_pm #(.PMC_WORD(PMC_WORD), .NEXT_PTR(PM_NEXT)) pm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (acc_wr && dw_idx == DW_PM_CTL),
      .wb        (wb),
      .pme_event (pme_event),
      .pwr_state (pwr_state),
      .hdr_word  (pm_hdr_w),
      .ctl_word  (pm_ctl_w)
   );

   if (HAS_VPD) begin : g_vpd
      pcicfg_vpd vpd_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .hdr_hit  (acc_wr && dw_idx == DW_VPD_HDR),
         .dat_hit  (acc_wr && dw_idx == DW_VPD_DAT),
         .wb       (wb),
         .hdr_word (vpd_hdr_w),
         .dat_word (vpd_dat_w)
      );
   end else begin : g_no_vpd
      assign vpd_hdr_w = '0;
      assign vpd_dat_w = '0;
   end

   pcicfg_rdmux rdmux_i (
      .dw_idx    (dw_idx),
      .ident_w   (ident_w),
      .cmdstat_w (cmdstat_w),
      .vpd_hdr_w (vpd_hdr_w),
      .vpd_dat_w (vpd_dat_w),
      .pm_hdr_w  (pm_hdr_w),
      .pm_ctl_w  (pm_ctl_w),
      .rd_word   (rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         acc_rdata <= '0;
      else if (acc_rd)
         acc_rdata <= rd_word;
   end

endmodule

// File: rtl/pcicfg_regfile_chk.sv
module pcicfg_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  acc_addr,
   input logic        acc_rd,
   input logic        acc_wr,
   input logic [31:0] acc_rdata,
   input logic        fb2b_permit,
   input logic        addr_parity_err,
   input logic [15:0] cmd_bits,
   input logic        serr_req,
   input logic [1:0]  pwr_state
);
   AST_FB2B_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !fb2b_permit |-> !cmd_bits[9]); // R3

   AST_SERR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_parity_err && cmd_bits[8]) |=> serr_req); // R4

   AST_SERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      serr_req |-> $past(addr_parity_err && cmd_bits[8])); // R4

   AST_CMD_HARDWIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_bits[15:10] == 6'h00) && !cmd_bits[7]); // R5

   AST_CAP_POINTER: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && acc_addr[7:2] == 6'h0D) |=> (acc_rdata == 32'h0000_00DC)); // R6

   AST_PWR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_wr |=> $stable(pwr_state)); // R8

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> $stable(acc_rdata)); // R12

endmodule

bind pcicfg_regfile pcicfg_regfile_chk chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .acc_addr        (acc_addr),
   .acc_rd          (acc_rd),
   .acc_wr          (acc_wr),
   .acc_rdata       (acc_rdata),
   .fb2b_permit     (fb2b_permit),
   .addr_parity_err (addr_parity_err),
   .cmd_bits        (cmd_bits),
   .serr_req        (serr_req),
   .pwr_state       (pwr_state)
);

// File: tb/pcicfg_regfile_tb_top.sv
module pcicfg_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  acc_addr = '0;
   logic [3:0]  acc_be = '0;
   logic [31:0] acc_wdata = '0;
   logic        acc_rd = 1'b0, acc_wr = 1'b0;
   logic [31:0] acc_rdata;
   logic        rom_present = 1'b0;
   logic [15:0] rom_vendor = 16'h1234, rom_device = 16'hABCD;
   logic        fb2b_permit = 1'b0, addr_parity_err = 1'b0, pme_event = 1'b0;
   logic [15:0] cmd_bits;
   logic        serr_req;
   logic [1:0]  pwr_state;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   pcicfg_regfile dut_i (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      acc_addr = a;
      acc_rd   = 1'b1;
      @(negedge clk);
      acc_rd   = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      acc_addr  = a;
      acc_be    = be;
      acc_wdata = d;
      acc_wr    = 1'b1;
      @(negedge clk);
      acc_wr    = 1'b0;
   endtask

   // monitor: pops expected read data one cycle after each strobe
   initial begin
      forever begin
         @(posedge clk);
         if (acc_rd) begin
            @(negedge clk);
            check(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 cmd_bits", {16'h0, cmd_bits}, 32'h0);
      check("R1 pwr_state", {30'h0, pwr_state}, 32'h0);
      check("R1 serr_req", {31'h0, serr_req}, 32'h0);
      rd(8'hE0, 32'h0, "R1 pm control word");
      rd(8'h04, 32'h0010_0000, "R1 R6 command/status");

      rd(8'h00, 32'h8129_10EC, "R2 default ids");
      rom_present = 1'b1;
      rd(8'h00, 32'hABCD_1234, "R2 eeprom ids");

      rd(8'h34, 32'h0000_00DC, "R6 cap pointer");
      rd(8'h36, 32'h0000_00DC, "R12 low address bits ignored");
      rd(8'hDC, 32'h0002_6001, "R7 pm header");
      rd(8'h60, 32'h0000_0003, "R7 vpd header");

      wr(8'h04, 4'b0011, 32'h0000_FFFF);
      rd(8'h04, 32'h0010_0147, "R3 R5 write without permit");
      fb2b_permit = 1'b1;
      wr(8'h04, 4'b0011, 32'h0000_FFFF);
      rd(8'h04, 32'h0010_0347, "R3 write with permit");
      fb2b_permit = 1'b0;
      @(negedge clk);
      check("R3 permit dropped", {16'h0, cmd_bits}, 32'h0000_0147);
      wr(8'h04, 4'b0001, 32'h0000_0000);
      check("R10 cmd low lane only", {16'h0, cmd_bits}, 32'h0000_0100);
      wr(8'h04, 4'b1100, 32'hFFFF_0000);
      rd(8'h04, 32'h0010_0100, "R6 status ignores writes");

      @(negedge clk);
      addr_parity_err = 1'b1;
      @(negedge clk);
      addr_parity_err = 1'b0;
      check("R4 serr pulse", {31'h0, serr_req}, 32'h1);
      @(negedge clk);
      check("R4 serr single cycle", {31'h0, serr_req}, 32'h0);
      wr(8'h04, 4'b0010, 32'h0000_0000);
      addr_parity_err = 1'b1;
      @(negedge clk);
      addr_parity_err = 1'b0;
      check("R4 serr blocked", {31'h0, serr_req}, 32'h0);

      wr(8'hE0, 4'b0001, 32'h0000_00FF);
      check("R8 pwr_state port", {30'h0, pwr_state}, 32'h3);
      rd(8'hE0, 32'h0000_0003, "R8 power state readback");
      wr(8'hE0, 4'b0010, 32'h0000_0100);
      rd(8'hE0, 32'h0000_0103, "R9 pme enable");
      @(negedge clk);
      pme_event = 1'b1;
      @(negedge clk);
      pme_event = 1'b0;
      rd(8'hE0, 32'h0000_8103, "R9 pme status set");
      wr(8'hE0, 4'b0010, 32'h0000_0000);
      rd(8'hE0, 32'h0000_8003, "R9 write zero keeps status");
      wr(8'hE0, 4'b0010, 32'h0000_8000);
      rd(8'hE0, 32'h0000_0003, "R9 write one clears");
      @(negedge clk);
      acc_addr = 8'hE0; acc_be = 4'b0010; acc_wdata = 32'h0000_8000;
      acc_wr = 1'b1; pme_event = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0; pme_event = 1'b0;
      rd(8'hE0, 32'h0000_8003, "R9 set wins over clear");

      wr(8'h64, 4'b1111, 32'hAABB_CCDD);
      wr(8'h64, 4'b0101, 32'h1122_3344);
      rd(8'h64, 32'hAA22_CC44, "R10 byte enables on vpd data");
      wr(8'h60, 4'b1111, 32'hFFFF_FFFF);
      rd(8'h60, 32'hFFFF_0003, "R7 R10 vpd header low bytes read-only");

      wr(8'h40, 4'b1111, 32'hFFFF_FFFF);
      rd(8'h40, 32'h0, "R11 reserved 40h");
      rd(8'h70, 32'h0, "R11 reserved 70h");
      rd(8'hF0, 32'h0, "R11 reserved F0h");
      check("R11 outputs untouched", {14'h0, pwr_state, cmd_bits}, 32'h0003_0000);

      repeat (3) @(negedge clk);
      check("R12 rdata holds", acc_rdata, 32'h0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule